// File: doc/BRIEF.md
# Page Write Buffer Controller

This block sits between the serial command front end of a byte-wide non-volatile memory and its storage array. Once a write command's address is known, the front end pulses `start_i` with that address. Each received data byte then arrives on `byte_vld_i`/`byte_i`. The block keeps the bytes in a page buffer, together with a per-byte mask of the offsets that were received. Only the low offset bits of the address advance from byte to byte, so a long burst wraps inside its page and overwrites the bytes sent earlier at the same offsets.

Nothing reaches the array until `commit_i` pulses, which happens when chip select is released. A commit is honoured only when `allow_i` is high, `partial_i` reports that the last byte was complete, and at least one byte arrived. Any other commit throws the buffer away. An honoured commit starts a self-timed program cycle of `WRITE_CYCLES` clocks. During that cycle `busy_o` stays high and the received bytes are walked out onto the array write port, one offset per clock. Offsets that were not received are skipped, so their old contents stay in place. On the last busy clock `wel_clr_o` pulses so that the front end can drop its write-enable latch.

Top module: `pwb_ctrl`

## Requirements
- R1: After reset, `busy_o`, `mem_we_o` and `wel_clr_o` are all low.
- R2: `start_i` loads the page from `addr_i[ADDR_W-1:5]` and the starting offset from `addr_i[4:0]`. Each accepted byte is stored at the current offset, and the offset then increases by one modulo 32 while the page bits stay fixed.
- R3: When more than 32 bytes arrive, the offset wraps and a later byte replaces the earlier byte at the same offset. Only the last byte for each offset is programmed.
- R4: No array write happens while bytes are being collected. Writes happen only after an honoured commit.
- R5: A commit with `partial_i` high, or with no byte received since `start_i`, discards the buffer. `busy_o` stays low and nothing is written.
- R6: A commit with `allow_i` low discards the buffer in the same way.
- R7: After an honoured commit, `busy_o` rises on the next clock and stays high for exactly `WRITE_CYCLES` clocks.
- R8: The program cycle writes each received offset exactly once at address {page, offset}. Locations that were not received, and all other pages, keep their contents.
- R9: `wel_clr_o` is high for exactly one clock per program cycle, and that clock is the last one with `busy_o` high.
- R10: While `busy_o` is high, `start_i`, `byte_vld_i` and `commit_i` are ignored. No extra write or program cycle follows from them.
- R11: When a byte strobe and a commit fall in the same clock, that byte is stored and is part of the committed page.
- R12: When `start_i` and a byte strobe fall in the same clock, the start is taken and that byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin collecting a page at `addr_i` |
| addr_i | input | ADDR_W | Start byte address |
| byte_vld_i | input | 1 | A data byte is present on `byte_i` |
| byte_i | input | 8 | Data byte |
| commit_i | input | 1 | Chip-select release pulse |
| partial_i | input | 1 | With `commit_i`: the last byte was incomplete |
| allow_i | input | 1 | With `commit_i`: the write is permitted |
| busy_o | output | 1 | Program cycle in progress |
| wel_clr_o | output | 1 | One-clock pulse ending the program cycle |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | 8 | Array write data |

## Verification
Two events can coincide in one clock: the last byte strobe and the commit (R11), or a start and a byte strobe (R12). The bench drives each pair in the same cycle on purpose. It then judges the result from the array contents after the program cycle, comparing them with a memory image that the bench computes from the wrap rule on its own. A sweep over every start offset, with burst lengths from one byte to beyond a page, drives the wrap rule through its corners. Bursts of start, byte and commit strobes sent during a busy window check that nothing leaks into the array.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef logic [7:0] pwb_byte_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FILL = 2'd1,
        PH_PROG = 2'd2
    } pwb_phase_e;
endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
    parameter int PAGE_BYTES = 32,
    localparam int OFF_W = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             wr_en_i,
    input  logic [OFF_W-1:0] wr_off_i,
    input  pwb_pkg::pwb_byte_t wr_data_i,
    input  logic [OFF_W-1:0] rd_off_i,
    output pwb_pkg::pwb_byte_t rd_data_o,
    output logic             rd_vld_o,
    output logic [PAGE_BYTES-1:0] mask_o
);
    typedef struct packed {
        logic [PAGE_BYTES-1:0][7:0] data;
        logic [PAGE_BYTES-1:0]      mask;
    } buf_t;

    buf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.mask = '0;
        end else if (wr_en_i) begin
            s_d.data[wr_off_i] = wr_data_i;
            s_d.mask[wr_off_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data_o = s_q.data[rd_off_i];
    assign rd_vld_o  = s_q.mask[rd_off_i];
    assign mask_o    = s_q.mask;

    // R5
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (mask_o == '0));

    // R2
    byte_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !clr_i) |=> (s_q.mask[$past(wr_off_i)] && s_q.data[$past(wr_off_i)] == $past(wr_data_i)));
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
    parameter int WRITE_CYCLES = 250000,
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    output logic             busy_o,
    output logic             last_o,
    output logic [CNT_W-1:0] step_o
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (t_q.busy) begin
            if (t_q.cnt == CNT_W'(WRITE_CYCLES - 1)) begin
                t_d.busy = 1'b0;
                t_d.cnt  = '0;
            end else begin
                t_d.cnt = t_q.cnt + CNT_W'(1);
            end
        end else if (launch_i) begin
            t_d.busy = 1'b1;
            t_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy_o = t_q.busy;
    assign step_o = t_q.cnt;
    assign last_o = t_q.busy && (t_q.cnt == CNT_W'(WRITE_CYCLES - 1));

    // R7
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_i && !busy_o) |=> (busy_o && step_o == '0));

    // R9
    last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !busy_o);

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !last_o) |=> busy_o);
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl #(
    parameter int ADDR_W       = 13,
    parameter int PAGE_BYTES   = 32,
    parameter int WRITE_CYCLES = 250000,
    localparam int OFF_W  = $clog2(PAGE_BYTES),
    localparam int PAGE_W = ADDR_W - OFF_W,
    localparam int CNT_W  = $clog2(WRITE_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    input  logic              commit_i,
    input  logic              partial_i,
    input  logic              allow_i,
    output logic              busy_o,
    output logic              wel_clr_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_data_o
);
    import pwb_pkg::*;

    typedef struct packed {
        pwb_phase_e        phase;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  ptr;
    } ctl_t;

    ctl_t c_d, c_q;

    logic                  buf_clr, buf_wr, launch;
    logic                  tmr_last, tmr_busy;
    logic [CNT_W-1:0]      tmr_step;
    logic [PAGE_BYTES-1:0] mask;
    logic                  rd_vld;
    pwb_byte_t             rd_data;
    logic                  walk;

    always_comb begin
        c_d     = c_q;
        buf_clr = 1'b0;
        buf_wr  = 1'b0;
        launch  = 1'b0;
        unique case (c_q.phase)
            PH_IDLE, PH_FILL: begin
                if (start_i) begin
                    c_d.phase = PH_FILL;
                    c_d.page  = addr_i[ADDR_W-1:OFF_W];
                    c_d.ptr   = addr_i[OFF_W-1:0];
                    buf_clr   = 1'b1;
                end else if (c_q.phase == PH_FILL) begin
                    buf_wr = byte_vld_i;
                    if (byte_vld_i) c_d.ptr = c_q.ptr + OFF_W'(1);
                    if (commit_i) begin
                        if (allow_i && !partial_i && (byte_vld_i || mask != '0)) begin
                            launch    = 1'b1;
                            c_d.phase = PH_PROG;
                        end else begin
                            buf_clr   = 1'b1;
                            c_d.phase = PH_IDLE;
                        end
                    end
                end
            end
            PH_PROG: begin
                if (tmr_last) begin
                    buf_clr   = 1'b1;
                    c_d.phase = PH_IDLE;
                end
            end
            default: c_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{phase: PH_IDLE, page: '0, ptr: '0};
        else        c_q <= c_d;
    end

    pwb_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (buf_clr),
        .wr_en_i   (buf_wr),
        .wr_off_i  (c_q.ptr),
        .wr_data_i (byte_i),
        .rd_off_i  (tmr_step[OFF_W-1:0]),
        .rd_data_o (rd_data),
        .rd_vld_o  (rd_vld),
        .mask_o    (mask)
    );

    pwb_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .busy_o   (tmr_busy),
        .last_o   (tmr_last),
        .step_o   (tmr_step)
    );

    assign walk       = tmr_busy && (tmr_step < CNT_W'(PAGE_BYTES));
    assign busy_o     = tmr_busy;
    assign wel_clr_o  = tmr_last;
    assign mem_we_o   = walk && rd_vld;
    assign mem_addr_o = {c_q.page, tmr_step[OFF_W-1:0]};
    assign mem_data_o = rd_data;

    // R10
    mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_busy && !tmr_last) |=> $stable(mask));

    // R2
    page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.phase == PH_FILL && !start_i) |=> (c_q.page == $past(c_q.page)));

    // R4
    no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.phase != PH_PROG) |-> !mem_we_o);

    // R7
    prog_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.phase == PH_PROG) |-> tmr_busy);
endmodule

// File: tb/pwb_ctrl_bench.sv
module pwb_ctrl_bench;
    localparam int AW = 7;
    localparam int PG = 32;
    localparam int WC = 40;
    localparam int MEMN = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, byte_vld_i = 0, commit_i = 0, partial_i = 0, allow_i = 0;
    logic [AW-1:0] addr_i = '0;
    logic [7:0] byte_i = '0;
    logic busy_o, wel_clr_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [7:0] mem_data_o;

    int checks = 0, failures = 0;
    int wr_cnt = 0, wel_cnt = 0, wel_bad = 0;
    logic [7:0] bmem [MEMN];
    logic [7:0] emem [MEMN];

    always #10 clk = ~clk;

    pwb_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PG), .WRITE_CYCLES(WC)) u_pwb_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .commit_i(commit_i),
        .partial_i(partial_i), .allow_i(allow_i), .busy_o(busy_o),
        .wel_clr_o(wel_clr_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_data_o(mem_data_o)
    );

    always @(posedge clk) begin
        if (mem_we_o) begin
            bmem[mem_addr_o] <= mem_data_o;
            wr_cnt <= wr_cnt + 1;
        end
        if (wel_clr_o) wel_cnt <= wel_cnt + 1;
        if (wel_clr_o && !busy_o) wel_bad <= wel_bad + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0, first = -1;
        for (int a = 0; a < MEMN; a++)
            if (bmem[a] !== emem[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        if (first < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, int'(bmem[first]), int'(emem[first]));
    endtask

    task automatic do_start(input int a);
        @(negedge clk);
        start_i = 1; addr_i = AW'(a);
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        @(negedge clk);
        byte_vld_i = 1; byte_i = d;
        @(negedge clk);
        byte_vld_i = 0;
    endtask

    // commit; returns with busy sampled on the negedge after the commit edge
    task automatic do_commit(input bit part, input bit alw);
        @(negedge clk);
        commit_i = 1; partial_i = part; allow_i = alw;
        @(negedge clk);
        commit_i = 0; partial_i = 0; allow_i = 0;
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        while (busy_o) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [7:0] dgen(input int s, input int i);
        return 8'((s * 13 + i * 29 + 5) & 255);
    endfunction

    task automatic run_write(input int a, input int n, input int s);
        int bcyc, w0, e0;
        do_start(a);
        for (int i = 0; i < n; i++) begin
            send_byte(dgen(s, i));
            emem[(a & ~(PG - 1)) | ((a + i) & (PG - 1))] = dgen(s, i);
        end
        @(negedge clk);
        // R4: nothing written during collection
        chk(wr_cnt == 0, "R4", wr_cnt, 0);
        e0 = wel_cnt;
        do_commit(1'b0, 1'b1);
        wait_busy(bcyc);
        // R7
        chk(bcyc == WC, "R7", bcyc, WC);
        // R9
        chk(wel_cnt - e0 == 1 && wel_bad == 0, "R9", wel_cnt - e0, 1);
        // R2 R3 R8
        cmp_mem("R2/R3/R8 image");
        w0 = (n > PG) ? PG : n;
        chk(wr_cnt == w0, "R8 write count", wr_cnt, w0);
        wr_cnt = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int bcyc;
        for (int a = 0; a < MEMN; a++) begin
            bmem[a] = 8'h00;
            emem[a] = 8'h00;
        end
        repeat (3) @(negedge clk);
        // R1
        chk(!busy_o && !mem_we_o && !wel_clr_o, "R1", int'(busy_o), 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy_o && !mem_we_o && !wel_clr_o, "R1 after release", int'(busy_o), 0);

        // sweep all start offsets, burst lengths 1..40, pages rotating
        for (int off = 0; off < PG; off++)
            run_write((off % 4) * PG + off, (off * 7) % 40 + 1, off);
        run_write(3 * PG + 5, 70, 99);

        // R5: partial byte
        wr_cnt = 0;
        do_start(10);
        send_byte(8'hA5);
        do_commit(1'b1, 1'b1);
        repeat (WC + 2) @(negedge clk);
        chk(!busy_o && wr_cnt == 0, "R5 partial", wr_cnt, 0);
        // R5: no byte
        do_start(20);
        do_commit(1'b0, 1'b1);
        repeat (WC + 2) @(negedge clk);
        chk(!busy_o && wr_cnt == 0, "R5 empty", wr_cnt, 0);
        // R6
        do_start(40);
        send_byte(8'h3C);
        do_commit(1'b0, 1'b0);
        repeat (WC + 2) @(negedge clk);
        chk(!busy_o && wr_cnt == 0, "R6", wr_cnt, 0);
        cmp_mem("R5/R6 image");

        // R10: strobes during busy
        do_start(64);
        send_byte(8'h11);
        emem[64] = 8'h11;
        do_commit(1'b0, 1'b1);
        do_start(96);
        send_byte(8'hEE);
        do_commit(1'b0, 1'b1);
        wait_busy(bcyc);
        repeat (WC + 2) @(negedge clk);
        chk(!busy_o && wr_cnt == 1, "R10 writes", wr_cnt, 1);
        cmp_mem("R10 image");
        wr_cnt = 0;

        // R11: last byte together with commit
        do_start(33);
        send_byte(8'h5A);
        emem[33] = 8'h5A;
        @(negedge clk);
        byte_vld_i = 1; byte_i = 8'hC3; commit_i = 1; allow_i = 1;
        emem[34] = 8'hC3;
        @(negedge clk);
        byte_vld_i = 0; commit_i = 0; allow_i = 0;
        wait_busy(bcyc);
        chk(bcyc == WC, "R11 busy", bcyc, WC);
        chk(wr_cnt == 2, "R11 writes", wr_cnt, 2);
        cmp_mem("R11 image");
        wr_cnt = 0;

        // R11: single byte arriving with commit is enough to launch
        do_start(70);
        @(negedge clk);
        byte_vld_i = 1; byte_i = 8'h77; commit_i = 1; allow_i = 1;
        emem[70] = 8'h77;
        @(negedge clk);
        byte_vld_i = 0; commit_i = 0; allow_i = 0;
        wait_busy(bcyc);
        chk(bcyc == WC && wr_cnt == 1, "R11 lone byte", wr_cnt, 1);
        cmp_mem("R11 lone image");
        wr_cnt = 0;

        // R12: start with byte in same cycle
        @(negedge clk);
        start_i = 1; addr_i = AW'(100); byte_vld_i = 1; byte_i = 8'h99;
        @(negedge clk);
        start_i = 0; byte_vld_i = 0;
        send_byte(8'h42);
        emem[100] = 8'h42;
        do_commit(1'b0, 1'b1);
        wait_busy(bcyc);
        chk(wr_cnt == 1, "R12 writes", wr_cnt, 1);
        cmp_mem("R12 image");

        chk(!busy_o && !mem_we_o, "R1 idle at end", int'(busy_o), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule